// File: doc/BRIEF.md
# Cascaded Legacy Interrupt Vector Encoder

This block gives the processor a single read-only status word that names the legacy interrupt line to service next. It spares software a conversation with the two cascaded 8-line interrupt controllers. The block takes the request and mask vectors of a primary controller, which serves lines 0 to 7, and of a secondary controller, which serves lines 8 to 15. It treats them as one 16-line space.

On a read, the block picks the lowest-numbered line whose request bit is set and whose mask bit is clear. Line 2 is never a candidate, because it carries the secondary controller's cascade. The block returns a vector byte equal to a fixed base plus that line number. When no line qualifies, the byte falls back to the base and a spurious flag is raised alongside it. The block ignores writes except for a one-cycle warning pulse. Reads are free of side effects: no request bit is acknowledged or cleared.

Top module: `isa_vector_encoder`

## Requirements
- R1: A line is a candidate only when its request bit is 1 and its mask bit is 0; a masked request is never reported.
- R2: Line 2 (primary bit 2, the cascade input) is never reported, even when it is requested and unmasked.
- R3: The lowest-numbered candidate wins; line 0 has the highest priority and line 15 the lowest. Lines 8 to 15 are secondary bits 0 to 7.
- R4: The read data is 0x20 plus the winning line number, so it lies in 0x20 to 0x2F.
- R5: With no candidate, the read data is 0x20 and `spurious` is 1 in the response cycle. With a candidate, `spurious` is 0.
- R6: A write (`wr_en`=1) changes nothing. It produces no `rd_valid`, it leaves `rd_data` unchanged, and it raises `wr_warn` for exactly the following cycle.
- R7: Reads are side-effect free: repeated reads with unchanged inputs return the same byte.
- R8: Read latency is one cycle. `rd_valid` is 1 in the cycle after `rd_en` and 0 otherwise. The data reflects the inputs present at the edge where `rd_en` is sampled, and `rd_data` holds its value between reads.
- R9: Synchronous active-low reset drives `rd_valid`, `spurious` and `wr_warn` to 0 and `rd_data` to 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe for the status word |
| wr_en | input | 1 | Write strobe (unsupported, warns only) |
| pri_req | input | 8 | Primary controller request bits, lines 0-7 |
| pri_mask | input | 8 | Primary controller mask bits, 1 = masked |
| sec_req | input | 8 | Secondary controller request bits, lines 8-15 |
| sec_mask | input | 8 | Secondary controller mask bits, 1 = masked |
| rd_valid | output | 1 | Read response valid, one cycle after rd_en |
| rd_data | output | 8 | Vector byte: 0x20 + winning line |
| spurious | output | 1 | No qualifying line at the read |
| wr_warn | output | 1 | One-cycle pulse after an ignored write |

## Verification
The assertions assume that the request and mask vectors are settled at each clock edge. They also assume that a read and a write strobe never arrive in the same cycle, since the warning and the response are judged separately. The stimulus changes the vectors and strobes only on the falling clock edge. It issues reads and writes in separate cycles, and it holds the inputs steady across back-to-back reads when it checks that a read has no side effects.

// File: rtl/isa_vec_pkg.sv
// Package: shared sizing constants for the cascaded interrupt vector encoder.
// Assumes two controllers of equal width, with the cascade on the primary side.
package isa_vec_pkg;
    localparam int unsigned CTRL_LINES   = 8;
    localparam int unsigned CASCADE_LINE = 2;
    localparam int unsigned DATA_W       = 8;
    localparam logic [7:0]  VEC_BASE     = 8'h20;
endpackage

// File: rtl/isa_line_qualify.sv
// Module: merges the two controllers' request and mask vectors into one
// candidate vector of 2*CTRL_LINES lines, with the cascade line removed.
// Assumes the secondary controller occupies the upper half of the line space.
module isa_line_qualify #(
    parameter int unsigned CTRL_LINES   = isa_vec_pkg::CTRL_LINES,
    parameter int unsigned CASCADE_LINE = isa_vec_pkg::CASCADE_LINE,
    localparam int unsigned NUM_LINES   = 2 * CTRL_LINES
) (
    input  logic [CTRL_LINES-1:0] pri_req,
    input  logic [CTRL_LINES-1:0] pri_mask,
    input  logic [CTRL_LINES-1:0] sec_req,
    input  logic [CTRL_LINES-1:0] sec_mask,
    output logic [NUM_LINES-1:0]  cand
);
    // One qualifier per line; the cascade line is tied off.
    for (genvar g = 0; g < CTRL_LINES; g++) begin : g_line
        if (g == CASCADE_LINE) begin : g_casc
            assign cand[g] = 1'b0;
        end else begin : g_pri
            assign cand[g] = pri_req[g] & ~pri_mask[g];
        end
        assign cand[CTRL_LINES + g] = sec_req[g] & ~sec_mask[g];
    end
endmodule

// File: rtl/isa_prio_scan.sv
// Module: fixed-priority scan that picks the lowest-numbered set line.
// Assumes lower index means higher priority; idx is 0 when nothing is set.
module isa_prio_scan #(
    parameter int unsigned NUM_LINES = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] cand,
    output logic [IDX_W-1:0]     idx,
    output logic                 found
);
    // Scan from the lowest priority upward, so the lowest index set wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/isa_vector_encoder.sv
// Module: top of the vector encoder. It qualifies and scans the two
// controllers' lines and registers a vector byte one cycle after a read.
// Assumes rd_en and wr_en are not asserted together. Writes are ignored
// apart from a one-cycle warning, and reads never alter any request.
module isa_vector_encoder #(
    parameter int unsigned CTRL_LINES   = isa_vec_pkg::CTRL_LINES,
    parameter int unsigned CASCADE_LINE = isa_vec_pkg::CASCADE_LINE,
    parameter int unsigned DATA_W       = isa_vec_pkg::DATA_W,
    parameter logic [DATA_W-1:0] VEC_BASE = DATA_W'(isa_vec_pkg::VEC_BASE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [CTRL_LINES-1:0] pri_req,
    input  logic [CTRL_LINES-1:0] pri_mask,
    input  logic [CTRL_LINES-1:0] sec_req,
    input  logic [CTRL_LINES-1:0] sec_mask,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  spurious,
    output logic                  wr_warn
);
    localparam int unsigned NUM_LINES = 2 * CTRL_LINES;
    localparam int unsigned IDX_W     = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] cand;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_found;
    logic [DATA_W-1:0]    vec_next;

    isa_line_qualify #(
        .CTRL_LINES   (CTRL_LINES),
        .CASCADE_LINE (CASCADE_LINE)
    ) u_qualify (
        .pri_req  (pri_req),
        .pri_mask (pri_mask),
        .sec_req  (sec_req),
        .sec_mask (sec_mask),
        .cand     (cand)
    );

    isa_prio_scan #(
        .NUM_LINES (NUM_LINES)
    ) u_scan (
        .cand  (cand),
        .idx   (win_idx),
        .found (win_found)
    );

    // Vector byte: the base plus the winning index (the index is 0 when none qualifies).
    assign vec_next = VEC_BASE + DATA_W'(win_idx);

    // Read response register: data is captured only on a read, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= VEC_BASE;
            spurious <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            spurious <= rd_en & ~win_found;
            if (rd_en) begin
                rd_data <= vec_next;
            end
        end
    end

    // Write warning: a one-cycle pulse after any write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_warn <= 1'b0;
        end else begin
            wr_warn <= wr_en;
        end
    end

    // R8: a response follows every read and only a read
    a_r8_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r8_no_valid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R8/R6: data holds between reads, so writes cannot disturb it
    a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R5: the spurious flag tracks an empty candidate set at the read
    a_r5_spur_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cand == '0) |=> (spurious && rd_data == VEC_BASE));
    a_r5_no_spur_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cand != '0) |=> !spurious);
    // R2: the cascade line never appears in a response
    a_r2_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !spurious) |-> rd_data != VEC_BASE + DATA_W'(CASCADE_LINE));
    // R6: a write yields a warning on the next cycle only
    a_r6_warn_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_warn);
    a_r6_warn_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_warn);
    // R4: every response lies inside the 16-entry vector range
    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data >= VEC_BASE && rd_data < VEC_BASE + DATA_W'(NUM_LINES)));
endmodule

// File: tb/isa_vector_encoder_test.sv
module isa_vector_encoder_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_en, wr_en;
    logic [7:0] pri_req, pri_mask, sec_req, sec_mask;
    logic       rd_valid, spurious, wr_warn;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    isa_vector_encoder uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .pri_req(pri_req), .pri_mask(pri_mask),
        .sec_req(sec_req), .sec_mask(sec_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .spurious(spurious), .wr_warn(wr_warn)
    );

    // Vector layout: {sec_req, sec_mask, pri_req, pri_mask, exp_data, exp_spur}
    localparam int NV = 11;
    localparam logic [40:0] VEC [NV] = '{
        {8'h00, 8'h00, 8'h01, 8'h00, 8'h20, 1'b0}, // R4 line 0
        {8'h00, 8'h00, 8'h04, 8'h00, 8'h20, 1'b1}, // R2 cascade alone -> none
        {8'h00, 8'h00, 8'h0C, 8'h00, 8'h23, 1'b0}, // R2 skip 2, take 3
        {8'h01, 8'h00, 8'hFF, 8'hFF, 8'h28, 1'b0}, // R1 primary all masked
        {8'h80, 8'h00, 8'h80, 8'h00, 8'h27, 1'b0}, // R3 primary beats secondary
        {8'h80, 8'h00, 8'h00, 8'h00, 8'h2F, 1'b0}, // R3 line 15
        {8'h00, 8'h00, 8'h30, 8'h10, 8'h25, 1'b0}, // R1 masked 4, take 5
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 1'b1}, // R5 empty
        {8'hFF, 8'hFE, 8'h00, 8'h00, 8'h28, 1'b0}, // R1 secondary mask
        {8'h06, 8'h02, 8'h00, 8'h00, 8'h2A, 1'b0}, // R3 line 10
        {8'h00, 8'h00, 8'h06, 8'h00, 8'h21, 1'b0}  // R3 line 1 over cascade
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] sr, sm, pr, pm,
                           input logic [7:0] exp_d, input logic exp_s,
                           input string tag);
        @(negedge clk);
        sec_req = sr; sec_mask = sm; pri_req = pr; pri_mask = pm;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " R8 valid"}, {7'b0, rd_valid}, 8'h01);
        chk({tag, " data"}, rd_data, exp_d);
        chk({tag, " R5 spurious"}, {7'b0, spurious}, {7'b0, exp_s});
        @(negedge clk);
        chk({tag, " R8 valid drops"}, {7'b0, rd_valid}, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        pri_req = '0; pri_mask = '0; sec_req = '0; sec_mask = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 rd_valid", {7'b0, rd_valid}, 8'h00);
        chk("R9 rd_data", rd_data, 8'h20);
        chk("R9 spurious", {7'b0, spurious}, 8'h00);
        chk("R9 wr_warn", {7'b0, wr_warn}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][40:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:9],
                    VEC[i][8:1], VEC[i][0], $sformatf("vec%0d", i));
        end

        // R6: write after a 0x2F read leaves data alone and warns once
        do_read(8'h80, 8'h00, 8'h00, 8'h00, 8'h2F, 1'b0, "R6 setup");
        @(negedge clk);
        pri_req = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 warn", {7'b0, wr_warn}, 8'h01);
        chk("R6 no valid", {7'b0, rd_valid}, 8'h00);
        chk("R6 data kept", rd_data, 8'h2F);
        @(negedge clk);
        chk("R6 warn ends", {7'b0, wr_warn}, 8'h00);
        chk("R6 data still kept", rd_data, 8'h2F);

        // R7: back-to-back reads, same inputs, same answer
        do_read(8'h00, 8'h00, 8'h08, 8'h00, 8'h23, 1'b0, "R7 first");
        do_read(8'h00, 8'h00, 8'h08, 8'h00, 8'h23, 1'b0, "R7 second");

        // R8: the data follows the inputs present at the read edge
        @(negedge clk);
        pri_req = 8'h40; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; pri_req = 8'h01;
        chk("R8 sampled at read", rd_data, 8'h26);

        // R9: reset mid-run restores the base
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset data", rd_data, 8'h20);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule